// File: doc/BRIEF.md
# Clock Control Register with CPU Clock Divider and Clock-Pin Gating

This block holds a 16-bit control word that software writes as a whole. The word sets three things. The first is the rate of the CPU clock relative to the incoming PLL clock: full rate, two thirds or one third. The second is how the external clock-output pin behaves in each power mode. The third is whether that pin is silenced while the crystal oscillator gain is being retuned. The CPU clock is the PLL clock gated by an enable that is registered on the falling edge. The pin select is registered the same way. This keeps both outputs free of glitches when the ratio, the mode or the settings change.

The register port is a plain write strobe with a data word. The read word is always visible. There is no valid/ready handshake and no back-pressure: every strobed write is taken on the next rising PLL clock edge. Power mode and gain-change status are level inputs that may change at any time.

Top module: `clkctl_top`

## Requirements
- R1: After reset the read word is 0x0335.
- R2: Only bits 14, 13:12 and 9:8 are writable. Bits 5, 4, 2 and 0 always read as 1, and every other bit always reads as 0, whatever value is written.
- R3: A write whose bits 9:8 equal 10 leaves the ratio field at its previous value, while the other writable fields of the same write still take effect.
- R4: The ratio field sets the CPU clock. Code 00 gives one CPU pulse per PLL cycle. Code 01 gives two pulses every three PLL cycles, with an enable pattern of 1,1,0. Code 11 gives one pulse every three PLL cycles.
- R5: A new ratio takes effect only at the end of the divider's three-cycle period. Every CPU clock high pulse lasts exactly one PLL high phase, so no runt pulse appears.
- R6: With pin code (bits 13:12) 00, the pin drives the clock with its output enabled in all four power modes. The modes are encoded 00 normal, 01 software standby, 10 deep standby and 11 standby cancellation.
- R7: With pin code 01, the pin drives the clock in normal mode and is held low, with its output enabled, in the three standby modes.
- R8: With pin code 10, the pin drives the clock in normal mode and is tri-stated (output enable 0, drive value 0) in the three standby modes.
- R9: With pin code 11, the pin is tri-stated in every power mode.
- R10: While the gain-change input is high and bit 14 is 1, a pin that would drive the clock is held low instead. When bit 14 is 0, the clock keeps running during the gain change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pll_clk | input | 1 | PLL clock; clocks the register and the divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, taken on the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current register read word |
| pwr_mode | input | 2 | Power mode: 00 normal, 01 sw standby, 10 deep standby, 11 cancellation |
| osc_gain_busy | input | 1 | High while the oscillator gain is being changed |
| cpu_clk | output | 1 | Divided CPU clock |
| cko_out | output | 1 | Clock pin drive value |
| cko_oe | output | 1 | Clock pin output enable |

## Verification
The divider is tried with each legal ratio code by counting CPU pulses over a 30-cycle window. The counts of 30, 20 and 10 distinguish the three patterns. A write of the prohibited code is then checked to leave the count unchanged. A pulse-width monitor runs while the ratio is switched back and forth at arbitrary phases, which shows whether switches wait for the period boundary. The pin is observed in all sixteen pairs of pin code and power mode. Each observation separates running clock, held low and tri-state. The gain-change input is then tried with bit 14 both set and clear, which shows the silencing and its override.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int REG_W = 16;
  localparam logic [REG_W-1:0] FIXED_ONES = 16'h0035;

  localparam logic [1:0] RATIO_FULL  = 2'b00;
  localparam logic [1:0] RATIO_TWO3  = 2'b01;
  localparam logic [1:0] RATIO_BAD   = 2'b10;
  localparam logic [1:0] RATIO_THIRD = 2'b11;

  localparam logic [1:0] MODE_NORMAL = 2'b00;

  localparam logic [1:0] PIN_CODE_RUN  = 2'b00;
  localparam logic [1:0] PIN_CODE_LOW  = 2'b01;
  localparam logic [1:0] PIN_CODE_FLT  = 2'b10;
  localparam logic [1:0] PIN_CODE_OFF  = 2'b11;

  typedef enum logic [1:0] {
    PIN_CLK = 2'd0,
    PIN_LOW = 2'd1,
    PIN_HIZ = 2'd2
  } pin_sel_e;
endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             gain_gate,
  output logic [1:0]       pin_code,
  output logic [1:0]       ratio
);
  logic       gain_q;
  logic [1:0] pin_q;
  logic [1:0] ratio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q  <= 1'b0;
      pin_q   <= PIN_CODE_RUN;
      ratio_q <= RATIO_THIRD;
    end else if (wr_en) begin
      gain_q <= wr_data[14];
      pin_q  <= wr_data[13:12];
      if (wr_data[9:8] != RATIO_BAD) ratio_q <= wr_data[9:8];
    end
  end

  always_comb begin
    rd_data        = FIXED_ONES;
    rd_data[14]    = gain_q;
    rd_data[13:12] = pin_q;
    rd_data[9:8]   = ratio_q;
  end

  assign gain_gate = gain_q;
  assign pin_code  = pin_q;
  assign ratio     = ratio_q;

  assert_bad_ratio_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[9:8] == RATIO_BAD) |=> $stable(ratio_q));
  assert_ratio_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_q != RATIO_BAD);
endmodule

// File: rtl/clkctl_div.sv
module clkctl_div
  import clkctl_pkg::*;
#(
  parameter int PHASES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ratio,
  output logic       cpu_clk
);
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0] phase_q;
  logic [1:0]    act_q;
  logic          en_d, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      act_q   <= RATIO_THIRD;
    end else begin
      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      if (phase_q == LAST) act_q <= ratio;
    end
  end

  always_comb begin
    unique case (act_q)
      RATIO_FULL: en_d = 1'b1;
      RATIO_TWO3: en_d = (phase_q != LAST);
      RATIO_THIRD: en_d = (phase_q == '0);
      default:    en_d = 1'b1;
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign cpu_clk = clk & en_q;

  assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST);
  assert_switch_on_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(phase_q) == LAST);
endmodule

// File: rtl/clkctl_pin.sv
module clkctl_pin
  import clkctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       gain_busy,
  input  logic       gain_gate,
  input  logic [1:0] pin_code,
  output logic       cko_out,
  output logic       cko_oe
);
  pin_sel_e sel_d, sel_q;
  logic     standby;

  assign standby = (mode != MODE_NORMAL);

  always_comb begin
    sel_d = PIN_CLK;
    unique case (pin_code)
      PIN_CODE_RUN: sel_d = PIN_CLK;
      PIN_CODE_LOW: sel_d = standby ? PIN_LOW : PIN_CLK;
      PIN_CODE_FLT: sel_d = standby ? PIN_HIZ : PIN_CLK;
      default:      sel_d = PIN_HIZ;
    endcase
    if (sel_d == PIN_CLK && gain_busy && gain_gate) sel_d = PIN_LOW;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= PIN_LOW;
    else        sel_q <= sel_d;
  end

  assign cko_oe  = (sel_q != PIN_HIZ);
  assign cko_out = clk & (sel_q == PIN_CLK);

  assert_hiz_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cko_oe |-> !cko_out);
  assert_off_code_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pin_code) == PIN_CODE_OFF && pin_code == PIN_CODE_OFF) |-> !cko_oe);
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int PHASES = 3
) (
  input  logic             pll_clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [1:0]       pwr_mode,
  input  logic             osc_gain_busy,
  output logic             cpu_clk,
  output logic             cko_out,
  output logic             cko_oe
);
  logic       gain_gate;
  logic [1:0] pin_code;
  logic [1:0] ratio;

  clkctl_regs u_regs (
    .clk(pll_clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_data(reg_wdata),
    .rd_data(reg_rdata), .gain_gate(gain_gate), .pin_code(pin_code), .ratio(ratio)
  );

  clkctl_div #(.PHASES(PHASES)) u_div (
    .clk(pll_clk), .rst_n(rst_n), .ratio(ratio), .cpu_clk(cpu_clk)
  );

  clkctl_pin u_pin (
    .clk(pll_clk), .rst_n(rst_n), .mode(pwr_mode), .gain_busy(osc_gain_busy),
    .gain_gate(gain_gate), .pin_code(pin_code), .cko_out(cko_out), .cko_oe(cko_oe)
  );
endmodule

// File: tb/clkctl_top_tb.sv
module clkctl_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int ST_CLK = 0, ST_LOW = 1, ST_HIZ = 2, ST_BAD = 3;

  logic        pll_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  pwr_mode = 2'b00;
  logic        osc_gain_busy = 1'b0;
  logic        cpu_clk, cko_out, cko_oe;

  int checks = 0;
  int errors = 0;
  int runts = 0;
  time rise_t = 0;

  clkctl_top u_dut (
    .pll_clk(pll_clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwr_mode(pwr_mode), .osc_gain_busy(osc_gain_busy),
    .cpu_clk(cpu_clk), .cko_out(cko_out), .cko_oe(cko_oe)
  );

  always #(HALF) pll_clk = ~pll_clk;

  always @(posedge cpu_clk) rise_t = $time;
  always @(negedge cpu_clk) if (rst_n && ($time - rise_t) != HALF) runts++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [15:0] d);
    @(negedge pll_clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge pll_clk); reg_wr = 1'b0;
  endtask

  task automatic count_pulses(output int n);
    n = 0;
    repeat (6) @(posedge pll_clk);
    for (int i = 0; i < 30; i++) begin
      @(posedge pll_clk); #2;
      if (cpu_clk) n++;
    end
  endtask

  task automatic observe(output int st);
    logic h, l, oe;
    @(posedge pll_clk); @(posedge pll_clk); #2;
    h = cko_out; oe = cko_oe;
    #5 l = cko_out;
    if (!oe) st = ST_HIZ;
    else if (h && !l) st = ST_CLK;
    else if (!h && !l) st = ST_LOW;
    else st = ST_BAD;
  endtask

  function automatic int pin_expect(input logic [1:0] code, input logic [1:0] md,
                                    input logic busy, input logic gbit);
    int s;
    if (code == 2'b11) s = ST_HIZ;
    else if (md == 2'b00) s = ST_CLK;
    else if (code == 2'b01) s = ST_LOW;
    else if (code == 2'b10) s = ST_HIZ;
    else s = ST_CLK;
    if (s == ST_CLK && busy && gbit) s = ST_LOW;
    return s;
  endfunction

  task automatic t_reset;
    check("R1 reset word", reg_rdata, 16'h0335);
  endtask

  task automatic t_fields;
    write_reg(16'hFFFF);
    check("R2 all-ones write", reg_rdata, 16'h7335);
    write_reg(16'h0000);
    check("R2 all-zero write", reg_rdata, 16'h0035);
    write_reg(16'h8ACA);
    check("R2 mixed write", reg_rdata, 16'h0035 | 16'h0000 | 16'h0000 | 16'h0000 | (16'h8ACA & 16'h7300) & ~16'h0200 | 16'h0000);
  endtask

  task automatic t_ratios;
    int n;
    write_reg(16'h0000); count_pulses(n); check("R4 ratio 00 pulses", n, 30);
    write_reg(16'h0100); count_pulses(n); check("R4 ratio 01 pulses", n, 20);
    write_reg(16'h0300); count_pulses(n); check("R4 ratio 11 pulses", n, 10);
  endtask

  task automatic t_bad_ratio;
    int n;
    write_reg(16'h0100);
    write_reg(16'h5200);
    check("R3 ratio kept, other fields taken", reg_rdata, 16'h5135);
    count_pulses(n);
    check("R3 divider unchanged", n, 20);
    write_reg(16'h0000);
  endtask

  task automatic t_switch;
    runts = 0;
    for (int k = 0; k < 9; k++) begin
      write_reg((k % 3 == 0) ? 16'h0000 : (k % 3 == 1) ? 16'h0300 : 16'h0100);
      repeat (k % 4) @(posedge pll_clk);
    end
    repeat (8) @(posedge pll_clk);
    check("R5 no runt pulses", runts, 0);
  endtask

  task automatic t_pin_matrix;
    int st;
    string req;
    for (int c = 0; c < 4; c++) begin
      write_reg(16'(c) << 12);
      for (int m = 0; m < 4; m++) begin
        pwr_mode = 2'(m);
        observe(st);
        req = (c == 0) ? "R6" : (c == 1) ? "R7" : (c == 2) ? "R8" : "R9";
        check($sformatf("%s pin code %0d mode %0d", req, c, m), st,
              pin_expect(2'(c), 2'(m), 1'b0, 1'b0));
      end
    end
    pwr_mode = 2'b00;
  endtask

  task automatic t_gain;
    int st;
    write_reg(16'h4000);
    osc_gain_busy = 1'b1; observe(st);
    check("R10 gated while busy", st, ST_LOW);
    osc_gain_busy = 1'b0; observe(st);
    check("R10 resumes after busy", st, ST_CLK);
    write_reg(16'h0000);
    osc_gain_busy = 1'b1; observe(st);
    check("R10 runs when gate bit clear", st, ST_CLK);
    write_reg(16'h6000); pwr_mode = 2'b10; observe(st);
    check("R10 tri-state not overridden", st, ST_HIZ);
    osc_gain_busy = 1'b0; pwr_mode = 2'b00;
  endtask

  initial begin
    repeat (3) @(posedge pll_clk);
    #2 t_reset();
    rst_n = 1'b1;
    t_fields();
    t_ratios();
    t_bad_ratio();
    t_switch();
    t_pin_matrix();
    t_gain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule